// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel TFT or STN panel. A horizontal pixel counter and a vertical line counter advance on a pixel-clock enable. From these counters and a small set of 16-bit registers the block derives line sync, frame sync, display enable and an active-area flag. It also raises a once-per-frame vertical interrupt that has a sticky status bit. Downstream fetch and pixel logic use the counters and strobes. This block does no memory access.

Horizontal quantities are programmed in 8-pixel character units minus one. Vertical quantities are programmed in lines minus one. Each sync position is the active size plus the front porch. Each total is the sync position plus the sync width plus the back porch. Timing and mode registers are held in a shadow copy that the counters use. The shadow copy reloads only at a frame boundary, or at any time while the display is off. After reset the registers hold an 800x525 total mode: 640x480 active, line sync at pixel 656 for 32 pixels, frame sync at line 490 for 2 lines.

Top module: `lcdt_timing`

## Requirements
- R1: While control bit 0 is clear (including after reset), both counters are held at zero. Line sync, frame sync and display enable sit at their inactive levels, which follow the polarity bits of the mode register.
- R2: The horizontal counter runs from 0 to (HT+1)*8-1, where HT is bits 7:0 of register 0. Line sync is asserted for pixels from (HS+1)*8 up to but not including (HS+1)*8+(HW+1)*8. HS is bits 7:0 and HW is bits 15:12 of register 1.
- R3: The vertical counter steps when the horizontal counter wraps, and runs from 0 to VT, where VT is bits 10:0 of register 3. Frame sync is asserted for lines from VS+1 up to but not including VS+1+VW+1. VS is bits 10:0 and VW is bits 15:12 of register 4.
- R4: The active-area flag is high while the pixel count is at most (HA+1)*8-1 and the line count is at most VA. HA is bits 15:8 of register 0 and VA is bits 10:0 of register 2. Display enable is that flag, inverted when mode bit 13 is set.
- R5: Mode register (register 5) bit 15 inverts frame sync and bit 14 inverts line sync. Bit 12 drives the data-invert output.
- R6: With mode bit 9 set, line sync is held inactive for the whole frame-sync period. With mode bit 8 set, frame sync is held inactive.
- R7: Interrupt register (register 6) bit 12 is the enable and bit 0 is a sticky status. The status is set on the clock edge where the line counter enters the first frame-sync line. A write to register 6 with bit 0 at zero clears the status, but a set in the same cycle wins. The interrupt output equals status AND enable. Reading register 6 returns the enable in bit 12 and the status in bit 0.
- R8: Writes to registers 0 to 5 while the display runs take effect only after the last pixel of the last line of the current frame.
- R9: Control register (register 7) bit 0 starts and stops the counters. Bit 4 drives the panel power output.
- R10: The counters advance only in cycles where the pixel-clock enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 16 | Register read data |
| hcnt_o | output | 11 | Pixel counter |
| vcnt_o | output | 11 | Line counter |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Display enable |
| active_o | output | 1 | Active-area flag, always active high |
| data_inv_o | output | 1 | Data bus inversion level |
| irq_o | output | 1 | Vertical interrupt |
| panel_pwr_o | output | 1 | Panel power control |

## Verification
The hardest case to produce is a status-clear write that lands in the same cycle as the edge that sets the status. The bench tracks the raster position in its own model. It issues the clearing write exactly when the model reports the last pixel of the line before frame sync. A second difficult case is a mid-frame change to the sync and mode registers. The bench writes these during an active frame and compares every cycle until the frame rolls over, so an early application of the new values shows up at once. Gaps in the pixel enable are mixed in so that counter holds occur at wrap points as well as inside lines.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;
    localparam int CH_W   = 8;    // character-unit field width
    localparam int LN_W   = 11;   // line field width
    localparam int SW_W   = 4;    // sync width field
    localparam int SW_LSB = 12;   // sync width field position

    localparam logic [ADDR_W-1:0] A_HCHAR = 3'd0;
    localparam logic [ADDR_W-1:0] A_HSYNC = 3'd1;
    localparam logic [ADDR_W-1:0] A_VACT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_VTOT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_VSYNC = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd5;
    localparam logic [ADDR_W-1:0] A_IRQ   = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd7;

    typedef struct packed {
        logic inv_frame;
        logic inv_line;
        logic de_low;
        logic data_inv;
        logic mask_line;
        logic mask_frame;
    } mode_t;

    typedef struct packed {
        logic [CH_W-1:0] h_total;
        logic [CH_W-1:0] h_active;
        logic [CH_W-1:0] h_sync_at;
        logic [SW_W-1:0] h_sync_len;
        logic [LN_W-1:0] v_active;
        logic [LN_W-1:0] v_total;
        logic [LN_W-1:0] v_sync_at;
        logic [SW_W-1:0] v_sync_len;
    } tcfg_t;

    function automatic logic [REG_W-1:0] mode_word(mode_t m);
        return {m.inv_frame, m.inv_line, m.de_low, m.data_inv,
                2'b00, m.mask_line, m.mask_frame, 8'h00};
    endfunction
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
#(
    parameter tcfg_t RST_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              frame_end,
    input  logic              vint_set,
    output tcfg_t             shadow_o,
    output mode_t             mode_o,
    output logic              run_o,
    output logic              pwr_o,
    output logic              irq_en_o,
    output logic              irq_st_o
);
    typedef struct packed {
        tcfg_t prog;
        tcfg_t shadow;
        mode_t mode_p;
        mode_t mode_s;
        logic  run;
        logic  pwr;
        logic  irq_en;
        logic  irq_st;
    } rstate_t;

    localparam rstate_t RST_ST = '{prog: RST_CFG, shadow: RST_CFG,
                                   mode_p: '0, mode_s: '0, run: 1'b0,
                                   pwr: 1'b0, irq_en: 1'b0, irq_st: 1'b0};

    rstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // shadow follows programmed values while idle or at a frame boundary
        if (!s_q.run || frame_end) begin
            s_d.shadow = s_q.prog;
            s_d.mode_s = s_q.mode_p;
        end
        if (vint_set) s_d.irq_st = 1'b1;
        if (wr_en) begin
            case (wr_addr)
                A_HCHAR: begin
                    s_d.prog.h_total  = wr_data[CH_W-1:0];
                    s_d.prog.h_active = wr_data[2*CH_W-1:CH_W];
                end
                A_HSYNC: begin
                    s_d.prog.h_sync_at  = wr_data[CH_W-1:0];
                    s_d.prog.h_sync_len = wr_data[SW_LSB +: SW_W];
                end
                A_VACT:  s_d.prog.v_active = wr_data[LN_W-1:0];
                A_VTOT:  s_d.prog.v_total  = wr_data[LN_W-1:0];
                A_VSYNC: begin
                    s_d.prog.v_sync_at  = wr_data[LN_W-1:0];
                    s_d.prog.v_sync_len = wr_data[SW_LSB +: SW_W];
                end
                A_MODE: begin
                    s_d.mode_p.inv_frame  = wr_data[15];
                    s_d.mode_p.inv_line   = wr_data[14];
                    s_d.mode_p.de_low     = wr_data[13];
                    s_d.mode_p.data_inv   = wr_data[12];
                    s_d.mode_p.mask_line  = wr_data[9];
                    s_d.mode_p.mask_frame = wr_data[8];
                end
                A_IRQ: begin
                    s_d.irq_en = wr_data[12];
                    if (!wr_data[0] && !vint_set) s_d.irq_st = 1'b0;
                end
                default: begin
                    s_d.run = wr_data[0];
                    s_d.pwr = wr_data[4];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_ST;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_HCHAR: rd_data = {s_q.prog.h_active, s_q.prog.h_total};
            A_HSYNC: rd_data = {s_q.prog.h_sync_len, 4'h0, s_q.prog.h_sync_at};
            A_VACT:  rd_data = {5'h00, s_q.prog.v_active};
            A_VTOT:  rd_data = {5'h00, s_q.prog.v_total};
            A_VSYNC: rd_data = {s_q.prog.v_sync_len, 1'b0, s_q.prog.v_sync_at};
            A_MODE:  rd_data = mode_word(s_q.mode_p);
            A_IRQ:   rd_data = {3'b000, s_q.irq_en, 11'h000, s_q.irq_st};
            default: rd_data = {11'h000, s_q.pwr, 3'b000, s_q.run};
        endcase
    end

    assign shadow_o = s_q.shadow;
    assign mode_o   = s_q.mode_s;
    assign run_o    = s_q.run;
    assign pwr_o    = s_q.pwr;
    assign irq_en_o = s_q.irq_en;
    assign irq_st_o = s_q.irq_st;
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
#(
    parameter int HP_W = CH_W + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pix_ce,
    input  tcfg_t           cfg,
    output logic [HP_W-1:0] hcnt_o,
    output logic [LN_W-1:0] vcnt_o,
    output logic            frame_end_o,
    output logic            vint_o,
    output logic            hs_act_o,
    output logic            vs_act_o,
    output logic            active_o
);
    localparam int HC_W = HP_W + 2;
    localparam int VC_W = LN_W + 2;

    typedef struct packed {
        logic [HP_W-1:0] h;
        logic [LN_W-1:0] v;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [HP_W-1:0] h_last, h_act_last;
    logic [HC_W-1:0] hs_beg, hs_end;
    logic [VC_W-1:0] vs_beg, vs_end;
    logic            line_end;

    always_comb begin
        h_last     = {cfg.h_total, 3'b111};
        h_act_last = {cfg.h_active, 3'b111};
        hs_beg = HC_W'({cfg.h_sync_at, 3'b000}) + HC_W'(8);
        hs_end = hs_beg + HC_W'({cfg.h_sync_len, 3'b000}) + HC_W'(8);
        vs_beg = VC_W'(cfg.v_sync_at) + VC_W'(1);
        vs_end = vs_beg + VC_W'(cfg.v_sync_len) + VC_W'(1);

        line_end    = run && pix_ce && (c_q.h == h_last);
        frame_end_o = line_end && (c_q.v == cfg.v_total);
        vint_o      = line_end && ((VC_W'(c_q.v) + VC_W'(1)) == vs_beg);

        c_d = c_q;
        if (!run) begin
            c_d = '0;
        end else if (pix_ce) begin
            if (c_q.h == h_last) begin
                c_d.h = '0;
                c_d.v = (c_q.v == cfg.v_total) ? '0 : c_q.v + LN_W'(1);
            end else begin
                c_d.h = c_q.h + HP_W'(1);
            end
        end

        hs_act_o = run && (HC_W'(c_q.h) >= hs_beg) && (HC_W'(c_q.h) < hs_end);
        vs_act_o = run && (VC_W'(c_q.v) >= vs_beg) && (VC_W'(c_q.v) < vs_end);
        active_o = run && (c_q.h <= h_act_last) && (c_q.v <= cfg.v_active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hcnt_o = c_q.h;
    assign vcnt_o = c_q.v;
endmodule

// File: rtl/lcdt_timing.sv
module lcdt_timing
    import lcdt_pkg::*;
#(
    parameter int RST_HTOT_CH = 99,
    parameter int RST_HACT_CH = 79,
    parameter int RST_HSYN_CH = 81,
    parameter int RST_HSW_CH  = 3,
    parameter int RST_VACT    = 479,
    parameter int RST_VTOT    = 524,
    parameter int RST_VSYN    = 489,
    parameter int RST_VSW     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_ce,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic [10:0] hcnt_o,
    output logic [10:0] vcnt_o,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic        active_o,
    output logic        data_inv_o,
    output logic        irq_o,
    output logic        panel_pwr_o
);
    localparam int HP_W = CH_W + 3;
    localparam tcfg_t RST_CFG = '{
        h_total:    CH_W'(RST_HTOT_CH),
        h_active:   CH_W'(RST_HACT_CH),
        h_sync_at:  CH_W'(RST_HSYN_CH),
        h_sync_len: SW_W'(RST_HSW_CH),
        v_active:   LN_W'(RST_VACT),
        v_total:    LN_W'(RST_VTOT),
        v_sync_at:  LN_W'(RST_VSYN),
        v_sync_len: SW_W'(RST_VSW)};

    tcfg_t shadow;
    mode_t mode;
    logic  run, irq_en, irq_status;
    logic  frame_end, vint, hs_act, vs_act, act;

    lcdt_regs #(.RST_CFG(RST_CFG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_end(frame_end), .vint_set(vint), .shadow_o(shadow),
        .mode_o(mode), .run_o(run), .pwr_o(panel_pwr_o),
        .irq_en_o(irq_en), .irq_st_o(irq_status));

    lcdt_scan #(.HP_W(HP_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(run), .pix_ce(pix_ce), .cfg(shadow),
        .hcnt_o(hcnt_o), .vcnt_o(vcnt_o), .frame_end_o(frame_end),
        .vint_o(vint), .hs_act_o(hs_act), .vs_act_o(vs_act), .active_o(act));

    always_comb begin
        hsync_o    = (hs_act && !(mode.mask_line && vs_act)) ^ mode.inv_line;
        vsync_o    = (vs_act && !mode.mask_frame) ^ mode.inv_frame;
        de_o       = act ^ mode.de_low;
        active_o   = act;
        data_inv_o = mode.data_inv;
        irq_o      = irq_status && irq_en;
    end
endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_ce,
    input logic        run,
    input logic        irq_status,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic [10:0] hcnt,
    input logic [10:0] vcnt
);
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hcnt == 11'd0 && vcnt == 11'd0));

    p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pix_ce) |=> (hcnt == $past(hcnt) + 11'd1 || hcnt == 11'd0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> ((hcnt == $past(hcnt) && vcnt == $past(vcnt)) ||
                     (hcnt == 11'd0 && vcnt == 11'd0)));

    p_irq_at_line_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status) |-> hcnt == 11'd0);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !(wr_en && wr_addr == 3'd6 && !wr_data[0])) |=> irq_status);
endmodule

bind lcdt_timing lcdt_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .run(run),
    .irq_status(irq_status), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hcnt(hcnt_o), .vcnt(vcnt_o));

// File: tb/lcdt_timing_tb.sv
module lcdt_timing_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd6;
    logic [15:0] rd_data;
    logic [10:0] hcnt_o, vcnt_o;
    logic hsync_o, vsync_o, de_o, active_o, data_inv_o, irq_o, panel_pwr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdt_timing u_dut (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .hcnt_o(hcnt_o), .vcnt_o(vcnt_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .active_o(active_o), .data_inv_o(data_inv_o), .irq_o(irq_o),
        .panel_pwr_o(panel_pwr_o));

    // reference model state: programmed (p_*) and in-use (a_*) settings
    int p_ht = 99, p_ha = 79, p_hs = 81, p_hw = 3, p_va = 479, p_vt = 524, p_vs = 489, p_vw = 1;
    int a_ht = 99, a_ha = 79, a_hs = 81, a_hw = 3, a_va = 479, a_vt = 524, a_vs = 489, a_vw = 1;
    bit [15:0] p_mode = 16'h0, a_mode = 16'h0;
    bit m_run = 0, m_pwr = 0, m_en = 0, m_st = 0;
    int m_h = 0, m_v = 0;

    typedef struct {
        int    h, v;
        bit    hs, vs, de, act, dinv, irq, pwr;
        bit [15:0] rd;
        string ph;
    } exp_t;
    exp_t q[$];

    function automatic int h_last();
        return (a_ht + 1) * 8 - 1;
    endfunction

    task automatic check(string tag, string ph, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s (%s): got %0h expected %0h at %0t", tag, ph, got, exp, $time);
        end
    endtask

    function automatic exp_t predict(string ph);
        exp_t e;
        int hsb, hse, vsb, vse;
        bit hs_a, vs_a;
        hsb = (a_hs + 1) * 8;
        hse = hsb + (a_hw + 1) * 8;
        vsb = a_vs + 1;
        vse = vsb + a_vw + 1;
        hs_a = m_run && m_h >= hsb && m_h < hse;
        vs_a = m_run && m_v >= vsb && m_v < vse;
        e.h = m_h;
        e.v = m_v;
        e.act = m_run && m_h <= (a_ha + 1) * 8 - 1 && m_v <= a_va;
        e.hs = (hs_a && !(a_mode[9] && vs_a)) ^ a_mode[14];
        e.vs = (vs_a && !a_mode[8]) ^ a_mode[15];
        e.de = e.act ^ a_mode[13];
        e.dinv = a_mode[12];
        e.irq = m_st && m_en;
        e.pwr = m_pwr;
        e.rd = {3'b000, m_en, 11'h000, m_st};
        e.ph = ph;
        return e;
    endfunction

    task automatic model_step(bit ce, bit we, bit [2:0] a, bit [15:0] d);
        bit le, fe, vi;
        le = m_run && ce && m_h == h_last();
        fe = le && m_v == a_vt;
        vi = le && (m_v + 1) == (a_vs + 1);
        if (!m_run || fe) begin
            a_ht = p_ht; a_ha = p_ha; a_hs = p_hs; a_hw = p_hw;
            a_va = p_va; a_vt = p_vt; a_vs = p_vs; a_vw = p_vw;
            a_mode = p_mode;
        end
        if (!m_run) begin
            m_h = 0; m_v = 0;
        end else if (ce) begin
            if (le) begin
                m_h = 0;
                m_v = fe ? 0 : m_v + 1;
            end else m_h = m_h + 1;
        end
        if (vi) m_st = 1;
        if (we) begin
            case (a)
                3'd0: begin p_ht = d[7:0]; p_ha = d[15:8]; end
                3'd1: begin p_hs = d[7:0]; p_hw = d[15:12]; end
                3'd2: p_va = d[10:0];
                3'd3: p_vt = d[10:0];
                3'd4: begin p_vs = d[10:0]; p_vw = d[15:12]; end
                3'd5: p_mode = d & 16'hF300;
                3'd6: begin m_en = d[12]; if (!d[0] && !vi) m_st = 0; end
                default: begin m_run = d[0]; m_pwr = d[4]; end
            endcase
        end
    endtask

    // driver: one clock of stimulus, then the expected item for that edge
    task automatic cyc(bit ce, bit we, bit [2:0] a, bit [15:0] d, string ph);
        @(negedge clk);
        pix_ce = ce; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        model_step(ce, we, a, d);
        q.push_back(predict(ph));
    endtask

    task automatic run_n(int n, string ph);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 16'h0, ph);
    endtask

    // monitor: pops one expected item per clock and compares all outputs
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R2 hcnt",  e.ph, int'(hcnt_o), e.h);
            check("R2 hsync", e.ph, int'(hsync_o), int'(e.hs));
            check("R3 vcnt",  e.ph, int'(vcnt_o), e.v);
            check("R3 vsync", e.ph, int'(vsync_o), int'(e.vs));
            check("R4 active", e.ph, int'(active_o), int'(e.act));
            check("R4 de",    e.ph, int'(de_o), int'(e.de));
            check("R5 datainv", e.ph, int'(data_inv_o), int'(e.dinv));
            check("R7 irq",   e.ph, int'(irq_o), int'(e.irq));
            check("R7 status readback", e.ph, int'(rd_data), int'(e.rd));
            check("R9 power", e.ph, int'(panel_pwr_o), int'(e.pwr));
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset hcnt", "reset", int'(hcnt_o), 0);
        check("R1 reset vcnt", "reset", int'(vcnt_o), 0);
        check("R1 reset hsync", "reset", int'(hsync_o), 0);
        check("R1 reset vsync", "reset", int'(vsync_o), 0);
        check("R1 reset de", "reset", int'(de_o), 0);
        check("R1 reset irq", "reset", int'(irq_o), 0);
        rst_n = 1'b1;

        // R1: idle outputs follow inverted polarity
        cyc(1'b1, 1'b1, 3'd5, 16'hE000, "R1 idle inverted");
        run_n(4, "R1 idle inverted");
        cyc(1'b1, 1'b1, 3'd5, 16'h1000, "R5 data invert");
        run_n(2, "R5 data invert");
        cyc(1'b1, 1'b1, 3'd5, 16'h0000, "R1 idle");

        // small mode: 32x6 total, 16x3 active, hsync 24..31, vsync line 4
        cyc(1'b1, 1'b1, 3'd0, 16'h0103, "setup");
        cyc(1'b1, 1'b1, 3'd1, 16'h0002, "setup");
        cyc(1'b1, 1'b1, 3'd2, 16'h0002, "setup");
        cyc(1'b1, 1'b1, 3'd3, 16'h0005, "setup");
        cyc(1'b1, 1'b1, 3'd4, 16'h0003, "setup");
        cyc(1'b1, 1'b1, 3'd6, 16'h1000, "R7 enable");
        cyc(1'b1, 1'b1, 3'd7, 16'h0011, "R9 start");
        run_n(400, "R2 R3 R4 R7 frames");

        // R7: clear status mid-frame
        cyc(1'b1, 1'b1, 3'd6, 16'h1000, "R7 clear");
        run_n(40, "R7 after clear");

        // R7: clear colliding with the setting edge (set wins)
        for (int i = 0; i < 400; i++) begin
            if (m_run && m_h == h_last() && m_v + 1 == a_vs + 1) begin
                cyc(1'b1, 1'b1, 3'd6, 16'h1000, "R7 clear vs set");
                break;
            end
            cyc(1'b1, 1'b0, 3'd0, 16'h0, "R7 approach");
        end
        run_n(20, "R7 after collision");
        cyc(1'b1, 1'b1, 3'd6, 16'h0000, "R7 disable");
        run_n(10, "R7 disabled");

        // R10: sparse pixel enable
        for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 1'b0, 3'd0, 16'h0, "R10 gaps");

        // R8, R5, R6: mid-frame writes apply at the frame boundary
        run_n(50, "R8 pre");
        cyc(1'b1, 1'b1, 3'd1, 16'h1001, "R8 hsync write");
        cyc(1'b1, 1'b1, 3'd5, 16'hE300, "R8 R5 R6 mode write");
        cyc(1'b1, 1'b1, 3'd4, 16'h1002, "R8 vsync write");
        run_n(300, "R8 R5 R6 new timing");
        cyc(1'b1, 1'b1, 3'd5, 16'h0200, "R6 line mask");
        run_n(200, "R6 line mask");
        cyc(1'b1, 1'b1, 3'd5, 16'h0100, "R6 frame mask");
        run_n(200, "R6 frame mask");

        // R9: stop the counters, power bit alone
        cyc(1'b1, 1'b1, 3'd7, 16'h0010, "R9 stop");
        run_n(6, "R9 stopped");
        cyc(1'b1, 1'b1, 3'd7, 16'h0000, "R9 power off");
        run_n(3, "R9 off");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule